// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one 8-bit value at a time into a character frame on a single output line that rests at logic 1. A producer offers a byte with a valid/ready handshake. An external divider supplies a one-cycle enable pulse at sixteen times the bit rate, and every bit period on the line is measured in those pulses. Each frame is built from four parts, in this order:

- one low start bit;
- the data bits, least significant first;
- an optional parity bit;
- a high stop period.

Two run-time inputs control the frame shape. One selects a stop period of 1, 1.5 or 2 bit times. The other selects no parity, even parity or odd parity. Both are captured together with the byte, so a change made during a frame only affects the next frame. A busy output is high for the whole frame. The ready output is its inverse, so the producer can start the next byte as soon as the line is idle again.

Top module: `serial_frame_tx`

## Requirements
- R1: Out of reset and between frames, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1.
- R2: A byte is taken only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until the frame ends. Any `in_valid`/`in_data` activity during a frame leaves the transmitted bits unchanged.
- R3: On the clock edge after acceptance, `tx_line` goes to 0 and stays there for 16 tick pulses (the start bit).
- R4: The 8 data bits follow the start bit, least significant bit first, each lasting 16 tick pulses.
- R5: The `cfg_parity` codes are: 0 none, 1 even, 2 odd, 3 none. With code 1, the parity bit equals the XOR of the data. With code 2, it is the inverse of that XOR. With either code, the parity bit lasts 16 ticks and sits between the last data bit and the stop period. With codes 0 and 3, no parity bit is sent.
- R6: The stop period drives `tx_line` to 1. Its length depends on `cfg_stop`: code 0 gives 16 ticks, code 1 gives 24 ticks, and codes 2 and 3 give 32 ticks. On the clock edge that takes the final stop tick, the block returns to idle.
- R7: `tx_busy` is 1 from the edge after acceptance through the edge that takes the final stop tick. With parity on and 1 stop bit, this is 11 bit times (176 ticks).
- R8: `cfg_stop` and `cfg_parity` are sampled at acceptance. Changing them during a frame does not alter that frame.
- R9: During a frame, `tx_line` changes only on a clock edge where `tick_16x` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block can accept a byte |
| tick_16x | input | 1 | Oversample enable, 16 per bit |
| cfg_stop | input | 2 | Stop length code (0: 1 bit, 1: 1.5 bits, 2/3: 2 bits) |
| cfg_parity | input | 2 | Parity code (0/3: none, 1: even, 2: odd) |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | Frame in progress |

## Verification
The bench drives every combination of stop and parity codes using the bytes 00, FF, 01, 80 and A5. These tell apart wrong bit order, stuck data bits and inverted parity. Tick pulses arrive either on every cycle or at random intervals. Random intervals show whether the line ever moves without a tick and whether bit lengths are counted in ticks rather than clocks. Some frames change the configuration, or hold valid high with a different byte, during the frame; these show whether settings are latched and whether the handshake is blocked. Random bytes and configurations fill the rest. The end of each stop period is checked on the exact tick that finishes it, which separates the 24-tick stop setting from the other two.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int DATA_W = 8;
    localparam int OSR    = 16;
    localparam int TICK_W = $clog2(2 * OSR + 1);
    localparam int IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2,
        STOP_TWO_ALT  = 2'd3
    } stop_sel_e;

    typedef enum logic [1:0] {
        PAR_NONE     = 2'd0,
        PAR_EVEN     = 2'd1,
        PAR_ODD      = 2'd2,
        PAR_NONE_ALT = 2'd3
    } par_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } tx_state_e;

    typedef struct packed {
        stop_sel_e stop;
        par_sel_e  par;
    } frame_cfg_t;

    function automatic logic [TICK_W-1:0] stop_ticks(stop_sel_e s);
        case (s)
            STOP_ONE:      return TICK_W'(OSR);
            STOP_ONE_HALF: return TICK_W'(OSR + OSR / 2);
            default:       return TICK_W'(2 * OSR);
        endcase
    endfunction

    function automatic logic parity_on(par_sel_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic parity_value(par_sel_e p, logic [DATA_W-1:0] d);
        return (^d) ^ (p == PAR_ODD);
    endfunction

endpackage

// File: rtl/sft_bit_timer.sv
module sft_bit_timer
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              bit_end
);

    logic [TICK_W-1:0] cnt;

    assign bit_end = run && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (bit_end) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the tick count never runs past the current bit length
    p_cnt_below_limit_r6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < limit));

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    input  par_sel_e          par,
    output logic              lsb,
    output logic              par_bit
);

    logic [DATA_W-1:0] shreg;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            shreg <= din;
            par_q <= parity_value(par, din);
        end else if (shift) begin
            shreg <= {1'b0, shreg[DATA_W-1:1]};
        end
    end

    assign lsb     = shreg[0];
    assign par_bit = par_q;

    // R4: each shift presents the next higher data bit
    p_shift_order_r4: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (lsb == $past(shreg[1])));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              tick_16x,
    input  logic [1:0]        cfg_stop,
    input  logic [1:0]        cfg_parity,
    output logic              tx_line,
    output logic              tx_busy
);

    tx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [IDX_W-1:0]  bit_idx;
    logic              accept;
    logic              bit_end;
    logic              shift;
    logic              lsb;
    logic              par_bit;
    logic [TICK_W-1:0] limit;

    assign in_ready = (state == S_IDLE);
    assign tx_busy  = (state != S_IDLE);
    assign accept   = in_valid && in_ready;
    assign shift    = (state == S_DATA) && bit_end;
    assign limit    = (state == S_STOP) ? stop_ticks(cfg_q.stop) : TICK_W'(OSR);

    sft_bit_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tx_busy),
        .tick    (tick_16x),
        .limit   (limit),
        .bit_end (bit_end)
    );

    sft_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .shift   (shift),
        .din     (in_data),
        .par     (par_sel_e'(cfg_parity)),
        .lsb     (lsb),
        .par_bit (par_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cfg_q   <= '{stop: STOP_ONE, par: PAR_NONE};
            bit_idx <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        state <= S_START;
                        cfg_q <= '{stop: stop_sel_e'(cfg_stop), par: par_sel_e'(cfg_parity)};
                    end
                end
                S_START: begin
                    if (bit_end) begin
                        state   <= S_DATA;
                        bit_idx <= '0;
                    end
                end
                S_DATA: begin
                    if (bit_end) begin
                        if (bit_idx == IDX_W'(DATA_W - 1)) begin
                            state <= parity_on(cfg_q.par) ? S_PAR : S_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                S_PAR: begin
                    if (bit_end) state <= S_STOP;
                end
                S_STOP: begin
                    if (bit_end) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            S_START: tx_line = 1'b0;
            S_DATA:  tx_line = lsb;
            S_PAR:   tx_line = par_bit;
            default: tx_line = 1'b1;
        endcase
    end

    // R1: an idle block holds the line high
    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);

    // R2, R3: acceptance starts a frame with a low line and blocks the handshake
    p_accept_start_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (tx_busy && !tx_line && !in_ready));

    // R9: without a tick the frame keeps its line level
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !tick_16x) |=> (tx_busy && $stable(tx_line)));

    // R8: the latched configuration is frozen for the whole frame
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && $past(tx_busy)) |-> $stable(cfg_q));

    // R7: a frame only ends on a tick
    p_end_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_busy) |-> $past(tick_16x));

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;
    localparam int BIT_TICKS  = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready;
    logic       tick_16x;
    logic [1:0] cfg_stop;
    logic [1:0] cfg_parity;
    logic       tx_line;
    logic       tx_busy;
    logic       dense;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_frame_tx u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .tick_16x   (tick_16x),
        .cfg_stop   (cfg_stop),
        .cfg_parity (cfg_parity),
        .tx_line    (tx_line),
        .tx_busy    (tx_busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    function automatic bit exp_par_on(input logic [1:0] p);
        return (p == 2'd1) || (p == 2'd2);
    endfunction

    function automatic int exp_stop(input logic [1:0] s);
        if (s == 2'd0) return 16;
        if (s == 2'd1) return 24;
        return 32;
    endfunction

    function automatic logic exp_line(input logic [7:0] d, input logic [1:0] p, input int idx);
        if (idx == 0) return 1'b0;
        if (idx <= 8) return d[idx-1];
        if (idx == 9 && exp_par_on(p)) begin
            logic x = 1'b0;
            for (int i = 0; i < 8; i++) x = x ^ d[i];
            return (p == 2'd2) ? ~x : x;
        end
        return 1'b1;
    endfunction

    initial begin
        tick_16x = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            tick_16x = dense ? 1'b1 : (($urandom % 3) == 0);
        end
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", MAX_CYCLES, 0);
        finish_run();
    end

    task automatic send(input logic [7:0] d, input logic [1:0] s, input logic [1:0] p,
                        input bit scramble, input bit hold_valid);
        int nbits;
        int total;
        int cnt;
        bit first;
        logic prev_line;
        logic prev_tick;
        nbits = 9 + (exp_par_on(p) ? 1 : 0);
        total = BIT_TICKS * nbits + exp_stop(s);
        @(negedge clk);
        in_data    = d;
        cfg_stop   = s;
        cfg_parity = p;
        in_valid   = 1'b1;
        check(in_ready == 1'b1, "R2", "ready before accept", int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = hold_valid;
        if (hold_valid) in_data = ~d;
        if (scramble) begin
            cfg_stop   = 2'(s + 2'd1);
            cfg_parity = 2'(p + 2'd1);
        end
        check(tx_busy == 1'b1, "R7", "busy after accept", int'(tx_busy), 1);
        check(tx_line == 1'b0, "R3", "start level", int'(tx_line), 0);
        cnt = 0;
        first = 1'b1;
        prev_line = tx_line;
        prev_tick = 1'b0;
        while (1) begin
            if (!first && !prev_tick)
                check(tx_line == prev_line, "R9", "line moved without tick", int'(tx_line), int'(prev_line));
            if (hold_valid)
                check(in_ready == 1'b0, "R2", "ready during frame", int'(in_ready), 0);
            if (tick_16x) begin
                cnt++;
                check(tx_busy == 1'b1, "R7", "busy inside frame", int'(tx_busy), 1);
                if (cnt <= BIT_TICKS * nbits) begin
                    if (((cnt - 1) % BIT_TICKS) == 7) begin
                        int idx = (cnt - 1) / BIT_TICKS;
                        logic e = exp_line(d, p, idx);
                        if (idx == 0)
                            check(tx_line == e, "R3", "start bit", int'(tx_line), int'(e));
                        else if (idx <= 8)
                            check(tx_line == e, "R4", $sformatf("data bit %0d", idx - 1), int'(tx_line), int'(e));
                        else
                            check(tx_line == e, "R5", "parity bit", int'(tx_line), int'(e));
                    end
                end else begin
                    check(tx_line == 1'b1, "R6", "stop level", int'(tx_line), 1);
                end
            end
            if (cnt == 40) in_valid = 1'b0;
            if (cnt == total) break;
            first = 1'b0;
            prev_line = tx_line;
            prev_tick = tick_16x;
            @(negedge clk);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(tx_busy == 1'b0, "R6", $sformatf("end after %0d ticks (R7)", total), int'(tx_busy), 0);
        check(tx_line == 1'b1, "R1", "idle line after frame", int'(tx_line), 1);
        check(in_ready == 1'b1, "R1", "ready after frame", int'(in_ready), 1);
    endtask

    initial begin
        logic [7:0] pats [5];
        void'($urandom(32'd4242));
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h01; pats[3] = 8'h80; pats[4] = 8'hA5;
        dense = 1'b0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = 8'h00;
        cfg_stop = 2'd0;
        cfg_parity = 2'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1, "R1", "reset line", int'(tx_line), 1);
        check(tx_busy == 1'b0, "R1", "reset busy", int'(tx_busy), 0);
        check(in_ready == 1'b1, "R1", "reset ready", int'(in_ready), 1);

        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                dense = ((s + p) % 2) == 0;
                send(pats[(s * 4 + p) % 5], 2'(s), 2'(p), 1'b0, 1'b0);
            end
        end

        dense = 1'b0;
        send(8'h3C, 2'd0, 2'd0, 1'b1, 1'b0);   // R8 config change mid-frame
        send(8'hC3, 2'd1, 2'd2, 1'b1, 1'b1);   // R8 and R2 together
        send(8'h5A, 2'd0, 2'd1, 1'b0, 1'b1);   // R2, 11-bit frame for R7

        for (int n = 0; n < 24; n++) begin
            dense = ($urandom % 4) == 0;
            send(8'($urandom), 2'($urandom), 2'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);
        end
        finish_run();
    end

endmodule